// File: doc/BRIEF.md
# Single-Line NMI Interrupt Controller

This block conditions one external non-maskable interrupt input and forwards it to a parent interrupt controller as one request line. The raw input passes through a two-flop synchroniser; a programmable two-bit trigger type then picks one of four conditions: low level, falling edge, high level or rising edge. A qualifying condition sets a pending flag. The flag is gated by an enable flag, and the result is registered onto the request output.

Software drives a single-cycle 32-bit register port. A write happens on the clock edge where the write strobe is high. Read data is a combinational function of the address. The pending flag is cleared by writing 1 to it. The enable register sits at one of two offsets, selected by the `MAP_VARIANT` parameter. In level modes, an acknowledge that arrives while the level is still asserted does not clear the flag, so the request fires again.

Top module: `nmi_line_ctrl`

## Requirements
- R1: After reset the control, pending and enable registers read 0 (trigger type 0 = active-low level, interrupt masked) and `irq_out` is 0.
- R2: A change on `nmi_in` made just before clock edge 1 reaches the pending flag at edge 3: two synchroniser flops, then the pending register.
- R3: Control bits [1:0] at offset 0x00 select the trigger: 0 = active-low level, 1 = falling edge, 2 = active-high level, 3 = rising edge. Bit 1 gives the active level and bit 0 selects edge mode.
- R4: In edge modes, an input held in its active state after an acknowledge does not set the pending flag again.
- R5: In level modes, an acknowledge issued while the level is still active leaves the pending flag set.
- R6: Pending is bit 0 at offset 0x04. Writing 1 to it clears the flag, writing 0 has no effect, and the other bits read 0.
- R7: When a qualifying event and a write-1 acknowledge fall in the same cycle, the pending flag stays set.
- R8: Enable is bit 0 at offset 0x08 when `MAP_VARIANT`=0 and at offset 0x34 when `MAP_VARIANT`=1. The other bits read 0, and the offset not chosen is unmapped.
- R9: `irq_out` is the registered AND of pending and enable. It changes one edge after either flag changes, and it stays 0 while enable is 0.
- R10: Control bits [31:2] read back exactly as they were written.
- R11: Reads of unmapped offsets return 0, and writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_in | input | 1 | Raw asynchronous interrupt input |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wr | input | 1 | Write strobe, taken on the rising clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| irq_out | output | 1 | Registered interrupt request to the parent controller |

## Verification
Register reads are combinational, so the bench samples them 1 ns after setting the address at a falling edge. A register write is visible at the falling edge after the rising edge that takes it. A change on `nmi_in` is first checked for absence two falling edges later and then for presence at the third, which pins the three-register path. `irq_out` is checked both at the falling edge right after an enable or acknowledge write (old value still expected) and one edge later (new value). The same-cycle event and acknowledge case is produced by issuing the clear on exactly the edge where the synchronised rising edge is seen.

// File: rtl/nmi_ctrl_pkg.sv
package nmi_ctrl_pkg;

  typedef enum logic [1:0] {
    TRIG_LVL_LO    = 2'd0,
    TRIG_EDGE_FALL = 2'd1,
    TRIG_LVL_HI    = 2'd2,
    TRIG_EDGE_RISE = 2'd3
  } trig_e;

  localparam int OFF_CTRL = 'h00;
  localparam int OFF_PEND = 'h04;

  function automatic int enable_offset(input int variant);
    return (variant != 0) ? 'h34 : 'h08;
  endfunction

  function automatic logic trig_level(input trig_e t);
    return t[1];
  endfunction

  function automatic logic trig_is_edge(input trig_e t);
    return t[0];
  endfunction

  // Qualifying condition from current and previous synchronised sample
  function automatic logic trig_hit(input trig_e t, input logic cur, input logic prev);
    logic lvl;
    lvl = trig_level(t);
    if (trig_is_edge(t)) return (cur == lvl) && (prev != lvl);
    else                 return (cur == lvl);
  endfunction

endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      chain_q[i] <= RST_VAL;
        else if (i == 0) chain_q[i] <= d;
        else             chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = chain_q[LAST];
endmodule

// File: rtl/nmi_detect.sv
module nmi_detect
  import nmi_ctrl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sample,
  input  trig_e mode,
  output logic  evt
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= sample;
  end

  assign evt = trig_hit(mode, sample, prev_q);

  AST_EDGE_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && trig_is_edge(mode)) |=> !(evt && mode == $past(mode))); // R4
endmodule

// File: rtl/nmi_regs.sv
module nmi_regs
  import nmi_ctrl_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int MAP_VARIANT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              evt,
  output trig_e             mode,
  output logic              irq_q
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFF_PEND);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(enable_offset(MAP_VARIANT));

  logic [31:0] ctrl_q;
  logic        pend_q, en_q;
  logic        hit_ctrl, hit_pend, hit_en, ack_wr;

  assign hit_ctrl = (reg_addr == A_CTRL);
  assign hit_pend = (reg_addr == A_PEND);
  assign hit_en   = (reg_addr == A_EN);
  assign ack_wr   = reg_wr && hit_pend && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      en_q   <= 1'b0;
    end else if (reg_wr) begin
      if (hit_ctrl) ctrl_q <= reg_wdata;
      if (hit_en)   en_q   <= reg_wdata[0];
    end
  end

  // set has priority over acknowledge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_q <= 1'b0;
    else if (evt)    pend_q <= 1'b1;
    else if (ack_wr) pend_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= pend_q & en_q;
  end

  always_comb begin
    reg_rdata = '0;
    if (hit_ctrl)      reg_rdata = ctrl_q;
    else if (hit_pend) reg_rdata = {31'd0, pend_q};
    else if (hit_en)   reg_rdata = {31'd0, en_q};
  end

  assign mode = trig_e'(ctrl_q[1:0]);

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> pend_q); // R7
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && !evt) |=> !pend_q); // R6
  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !irq_q); // R9
  AST_PEND_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt && !ack_wr) |=> $stable(pend_q)); // R6
endmodule

// File: rtl/nmi_line_ctrl.sv
module nmi_line_ctrl
  import nmi_ctrl_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int MAP_VARIANT = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_in,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq_out
);
  logic  sync_sample;
  logic  trig_evt;
  trig_e trig_mode;

  nmi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(nmi_in), .q(sync_sample)
  );

  nmi_detect u_detect (
    .clk(clk), .rst_n(rst_n), .sample(sync_sample), .mode(trig_mode), .evt(trig_evt)
  );

  nmi_regs #(.ADDR_W(ADDR_W), .MAP_VARIANT(MAP_VARIANT)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt(trig_evt),
    .mode(trig_mode), .irq_q(irq_out)
  );
endmodule

// File: tb/nmi_line_ctrl_tb.sv
module nmi_line_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nmi_in = 1'b1;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rdata_a, rdata_b;
  logic        irq_a, irq_b;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  nmi_line_ctrl #(.MAP_VARIANT(0)) dut_i (
    .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_a), .irq_out(irq_a)
  );
  nmi_line_ctrl #(.MAP_VARIANT(1)) dut_alt_i (
    .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_b), .irq_out(irq_b)
  );

  localparam logic [7:0] CTRL = 8'h00, PEND = 8'h04, EN_A = 8'h08, EN_B = 8'h34;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // called at a falling edge; write taken at the next rising edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] da, output logic [31:0] db);
    reg_addr = a;
    #1;
    da = rdata_a; db = rdata_b;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] a, b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(CTRL, a, b); chk("R1 ctrl", a, 0);
    rd(PEND, a, b); chk("R1 pend", a, 0);
    rd(EN_A, a, b); chk("R1 en", a, 0);
    chk("R1 irq", {31'd0, irq_a}, 0);

    // R3/R4/R5/R6 sweep over all trigger types
    for (int m = 0; m < 4; m++) begin
      logic act_lvl, is_edge;
      act_lvl = m[1];
      is_edge = m[0];
      wr(CTRL, m);
      nmi_in = ~act_lvl;
      wait_n(4);
      wr(PEND, 1);
      rd(PEND, a, b); chk("R3 idle", a, 0);
      nmi_in = act_lvl;
      wait_n(4);
      rd(PEND, a, b); chk("R3 fire", a, 1);
      wr(PEND, 1);
      rd(PEND, a, b);
      if (is_edge) chk("R4 edge oneshot", a, 0);
      else         chk("R5 level reassert", a, 1);
      nmi_in = ~act_lvl;
      wait_n(4);
      wr(PEND, 1);
      rd(PEND, a, b); chk("R6 cleared", a, 0);
    end

    // R2 latency in high-level mode
    wr(CTRL, 2);
    nmi_in = 1'b0; wait_n(4); wr(PEND, 1);
    nmi_in = 1'b1;
    wait_n(2);
    rd(PEND, a, b); chk("R2 not yet", a, 0);
    wait_n(1);
    rd(PEND, a, b); chk("R2 arrived", a, 1);
    nmi_in = 1'b0; wait_n(4); wr(PEND, 1);

    // R6 write 0 no effect, R7 priority, rising mode
    wr(CTRL, 3);
    nmi_in = 1'b1; wait_n(4);
    nmi_in = 1'b0; wait_n(4);
    wr(PEND, 0);
    rd(PEND, a, b); chk("R6 write0", a, 1);
    nmi_in = 1'b1;
    wait_n(2);
    wr(PEND, 1);
    rd(PEND, a, b); chk("R7 set wins", a, 1);
    wr(PEND, 1);
    rd(PEND, a, b); chk("R6 ack", a, 0);

    // R9 irq gating and timing
    nmi_in = 1'b0; wait_n(4);
    nmi_in = 1'b1; wait_n(4);
    chk("R9 masked", {31'd0, irq_a}, 0);
    wr(EN_A, 32'hFFFF_FFFF);
    chk("R9 irq old", {31'd0, irq_a}, 0);
    wait_n(1);
    chk("R9 irq set", {31'd0, irq_a}, 1);
    wr(PEND, 1);
    chk("R9 irq hold", {31'd0, irq_a}, 1);
    wait_n(1);
    chk("R9 irq drop", {31'd0, irq_a}, 0);

    // R8 variant offsets
    rd(EN_A, a, b); chk("R8 en bit0", a, 1); chk("R8 alt unmapped", b, 0);
    chk("R8 alt masked", {31'd0, irq_b}, 0);
    wr(EN_B, 32'hFFFF_FFFF);
    rd(EN_B, a, b); chk("R8 alt en", b, 1); chk("R8 main unmapped", a, 0);

    // R11 unmapped
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, a, b); chk("R11 read zero", a, 0);
    rd(8'h0C, a, b); chk("R11 read zero 0C", a, 0);
    rd(CTRL, a, b); chk("R11 ctrl untouched", a, 3);

    // R10 upper control bits
    wr(CTRL, 32'hA5A5_5A5E);
    rd(CTRL, a, b); chk("R10 readback", a, 32'hA5A5_5A5E);

    summary();
    $finish;
  end
endmodule